// File: doc/BRIEF.md
# Packed-SIMD Instruction Fault Selector

This block decides which fault, if any, a single packed-SIMD arithmetic instruction has to raise before it retires. Each cycle it takes the processor operating mode, a few control-register bits, the feature-present bit, the lock-prefix flag, the memory-operand description and the unmasked-numeric-fault indicator. One clock later it reports a one-hot fault code with a valid strobe.

The fault checks have a fixed priority. Invalid-opcode conditions come first, then device-not-available, then address faults on the memory operand, and the numeric fault comes last. Which checks apply to the memory operand depends on the mode. In real-address and virtual-8086 modes the operand must fit below 64 KiB. In 64-bit mode the address must be canonical. In the protected and compatibility modes a single segment-violation flag supplied from outside is used. An operand that is not aligned to 16 bytes is refused in every mode. A numeric fault becomes either the SIMD numeric fault or an invalid-opcode fault, depending on one control bit.

Top module: `sfc_fault_check`

## Requirements
- R1: `faultCode` is one-hot at all times: bit 0 none, bit 1 invalid opcode (UD), bit 2 device not available (NM), bit 3 general protection (GP), bit 4 stack fault (SS), bit 5 SIMD numeric (XM). Reset gives `faultValid`=0 and `faultCode`=6'b000001.
- R2: `faultValid` and `faultCode` are registered. After a clock edge that samples `reqValid`, `faultValid` equals that `reqValid`, and `faultCode` holds the verdict for the inputs sampled at that edge.
- R3: UD is reported when `cr0Em`=1, `cr4Fxsr`=0, `featPresent`=0 or `lockPrefix`=1. This check overrides every other one.
- R4: NM is reported when `cr0Ts`=1 and no R3 condition holds.
- R5: `cpuMode` is encoded as 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit. Codes 5 to 7 are treated as protected.
- R6: In 64-bit mode, a memory operand with `addrCanonical`=0 gives SS when `stackRef`=1 and GP otherwise. This applies when no R3 or R4 condition holds.
- R7: In real and virtual-8086 modes, a memory operand whose last byte (`memAddr`+15) exceeds 0xFFFF gives GP. This applies when no R3 or R4 condition holds.
- R8: In protected and compatibility modes, a memory operand with `segFault`=1 gives SS when `stackRef`=1 and GP otherwise. This applies when no R3 or R4 condition holds.
- R9: When none of R3, R4, R6, R7 or R8 applies, a memory operand with `memAddr[3:0]`≠0 gives GP in every mode.
- R10: With `memOp`=0, the inputs `memAddr`, `addrCanonical`, `stackRef` and `segFault` have no effect on the result.
- R11: When no earlier fault applies and `numFault`=1, the result is XM if `cr4XmmExc`=1 and UD if `cr4XmmExc`=0. With `numFault`=0 and no other fault, the result is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Instruction present for evaluation this cycle |
| cpuMode | input | 3 | Operating mode (R5 encoding) |
| cr0Em | input | 1 | Emulation control bit |
| cr0Ts | input | 1 | Task-switched control bit |
| cr4Fxsr | input | 1 | OS extended-state save support bit |
| cr4XmmExc | input | 1 | OS handles SIMD numeric faults bit |
| featPresent | input | 1 | SIMD extension reported present |
| lockPrefix | input | 1 | Instruction carries a lock prefix |
| memOp | input | 1 | Source operand is in memory |
| memAddr | input | ADDR_W | Effective address of the memory operand |
| addrCanonical | input | 1 | Address is canonical (64-bit mode) |
| stackRef | input | 1 | Reference goes through the stack segment |
| segFault | input | 1 | Segment check failed (protected/compatibility) |
| numFault | input | 1 | Unmasked SIMD numeric exception pending |
| faultValid | output | 1 | Registered verdict valid |
| faultCode | output | 6 | One-hot fault code (R1 encoding) |

## Verification
The bench sweeps every combination of the seven control and status bits in each of the five modes, across aligned, misaligned and out-of-range addresses. A design that ranked NM above UD, or let a numeric fault win over an address fault, would fail on the overlapping combinations. Directed cases probe the real-mode limit with 0xFFF0, which is legal, and 0xFFF1 and 0x10000, which are not. They also cover a misaligned non-canonical stack reference, which must give SS rather than GP, and register-operand requests whose address inputs are deliberately bad and must be ignored. Further random traffic adds the canonical, stack and segment flags, so that a swapped SS/GP choice or a check applied in the wrong mode is exposed.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpuMode_e;

  localparam int FAULT_W  = 6;
  localparam int FI_NONE  = 0;
  localparam int FI_UD    = 1;
  localparam int FI_NM    = 2;
  localparam int FI_GP    = 3;
  localparam int FI_SS    = 4;
  localparam int FI_XM    = 5;

  // memory-operand findings from the address path
  typedef struct packed {
    logic addrGp;
    logic addrSs;
    logic alignGp;
  } memChk_t;

  // resolved selection strobes, at most one set
  typedef struct packed {
    logic ud;
    logic nm;
    logic gp;
    logic ss;
    logic xm;
  } faultSel_t;
endpackage

// File: rtl/sfc_addr_check.sv
module sfc_addr_check
  import sfc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int ALIGN_BYTES = 16,
  parameter int LOW_LIMIT   = 32'h0000_FFFF
) (
  input  logic [2:0]        cpuMode,
  input  logic              memOp,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              addrCanonical,
  input  logic              stackRef,
  input  logic              segFault,
  output memChk_t           memChk
);
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);
  localparam logic [ADDR_W:0] LIMIT_X = (ADDR_W+1)'(LOW_LIMIT);
  localparam logic [ADDR_W:0] SPAN_X  = (ADDR_W+1)'(ALIGN_BYTES - 1);

  logic [ADDR_W:0] lastByte;
  logic            lowOut;
  logic            misAligned;

  assign lastByte   = {1'b0, memAddr} + SPAN_X;
  assign lowOut     = lastByte > LIMIT_X;
  assign misAligned = |memAddr[ALIGN_BITS-1:0];

  always_comb begin
    memChk = '0;
    if (memOp) begin
      unique case (cpuMode)
        MODE_REAL, MODE_V86: begin
          memChk.addrGp = lowOut;
        end
        MODE_LONG: begin
          memChk.addrSs = ~addrCanonical & stackRef;
          memChk.addrGp = ~addrCanonical & ~stackRef;
        end
        default: begin
          memChk.addrSs = segFault & stackRef;
          memChk.addrGp = segFault & ~stackRef;
        end
      endcase
      memChk.alignGp = misAligned;
    end
  end
endmodule

// File: rtl/sfc_prio_ctrl.sv
module sfc_prio_ctrl
  import sfc_pkg::*;
(
  input  logic      cr0Em,
  input  logic      cr0Ts,
  input  logic      cr4Fxsr,
  input  logic      cr4XmmExc,
  input  logic      featPresent,
  input  logic      lockPrefix,
  input  logic      numFault,
  input  memChk_t   memChk,
  output faultSel_t faultSel
);
  logic udEarly;
  logic memAny;

  assign udEarly = cr0Em | ~cr4Fxsr | ~featPresent | lockPrefix;
  assign memAny  = memChk.addrGp | memChk.addrSs | memChk.alignGp;

  always_comb begin
    faultSel = '0;
    if (udEarly) begin
      faultSel.ud = 1'b1;
    end else if (cr0Ts) begin
      faultSel.nm = 1'b1;
    end else if (memAny) begin
      // an address fault outranks the alignment fault
      if (memChk.addrSs)      faultSel.ss = 1'b1;
      else                    faultSel.gp = 1'b1;
    end else if (numFault) begin
      if (cr4XmmExc)          faultSel.xm = 1'b1;
      else                    faultSel.ud = 1'b1;
    end
  end
endmodule

// File: rtl/sfc_out_reg.sv
module sfc_out_reg
  import sfc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  faultSel_t          faultSel,
  output logic               faultValid,
  output logic [FAULT_W-1:0] faultCode
);
  logic [FAULT_W-1:0] codeNext;

  always_comb begin
    codeNext          = '0;
    codeNext[FI_UD]   = faultSel.ud;
    codeNext[FI_NM]   = faultSel.nm;
    codeNext[FI_GP]   = faultSel.gp;
    codeNext[FI_SS]   = faultSel.ss;
    codeNext[FI_XM]   = faultSel.xm;
    codeNext[FI_NONE] = ~|faultSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultValid <= 1'b0;
      faultCode  <= FAULT_W'(1) << FI_NONE;
    end else begin
      faultValid <= reqValid;
      faultCode  <= codeNext;
    end
  end
endmodule

// File: rtl/sfc_fault_check.sv
module sfc_fault_check
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        cpuMode,
  input  logic              cr0Em,
  input  logic              cr0Ts,
  input  logic              cr4Fxsr,
  input  logic              cr4XmmExc,
  input  logic              featPresent,
  input  logic              lockPrefix,
  input  logic              memOp,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              addrCanonical,
  input  logic              stackRef,
  input  logic              segFault,
  input  logic              numFault,
  output logic              faultValid,
  output logic [5:0]        faultCode
);
  memChk_t   memChk;
  faultSel_t faultSel;

  sfc_addr_check #(.ADDR_W(ADDR_W)) addr_i (
    .cpuMode       (cpuMode),
    .memOp         (memOp),
    .memAddr       (memAddr),
    .addrCanonical (addrCanonical),
    .stackRef      (stackRef),
    .segFault      (segFault),
    .memChk        (memChk)
  );

  sfc_prio_ctrl ctrl_i (
    .cr0Em       (cr0Em),
    .cr0Ts       (cr0Ts),
    .cr4Fxsr     (cr4Fxsr),
    .cr4XmmExc   (cr4XmmExc),
    .featPresent (featPresent),
    .lockPrefix  (lockPrefix),
    .numFault    (numFault),
    .memChk      (memChk),
    .faultSel    (faultSel)
  );

  sfc_out_reg out_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .faultSel   (faultSel),
    .faultValid (faultValid),
    .faultCode  (faultCode)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        cpuMode,
  input logic              cr0Em,
  input logic              cr0Ts,
  input logic              cr4Fxsr,
  input logic              cr4XmmExc,
  input logic              featPresent,
  input logic              lockPrefix,
  input logic              memOp,
  input logic [ADDR_W-1:0] memAddr,
  input logic              addrCanonical,
  input logic              stackRef,
  input logic              segFault,
  input logic              numFault,
  input logic              faultValid,
  input logic [5:0]        faultCode
);
  logic earlyUd;
  logic longBad;
  assign earlyUd = cr0Em | ~cr4Fxsr | ~featPresent | lockPrefix;
  assign longBad = memOp & (cpuMode == 3'd4) & ~addrCanonical;

  a_r1_code_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(faultCode) == 1);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> faultValid);

  a_r3_ud_first: assert property (@(posedge clk) disable iff (!rstN)
    earlyUd |=> faultCode == 6'b000010);

  a_r4_nm_second: assert property (@(posedge clk) disable iff (!rstN)
    (!earlyUd && cr0Ts) |=> faultCode == 6'b000100);

  a_r6_long_stack: assert property (@(posedge clk) disable iff (!rstN)
    (!earlyUd && !cr0Ts && longBad && stackRef) |=> faultCode == 6'b010000);

  a_r11_xm_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    faultCode == 6'b100000 |-> $past(numFault && cr4XmmExc));

  a_r10_regop_no_addr_fault: assert property (@(posedge clk) disable iff (!rstN)
    (!memOp) |=> (faultCode[3] == 1'b0 && faultCode[4] == 1'b0));
endmodule

bind sfc_fault_check sfc_checker #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/sfc_fault_check_tb_top.sv
`timescale 1ns/1ps
module sfc_fault_check_tb_top;
  localparam int ADDR_W = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [2:0]        cpuMode = '0;
  logic              cr0Em = 0, cr0Ts = 0, cr4Fxsr = 1, cr4XmmExc = 0;
  logic              featPresent = 1, lockPrefix = 0, memOp = 0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic              addrCanonical = 1, stackRef = 0, segFault = 0, numFault = 0;
  logic              faultValid;
  logic [5:0]        faultCode;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sfc_fault_check #(.ADDR_W(ADDR_W)) dut_i (.*);

  // reference verdict from the requirements; tag names the deciding rule
  function automatic logic [5:0] refCode(output string tag);
    logic early = cr0Em | ~cr4Fxsr | ~featPresent | lockPrefix;
    logic [ADDR_W:0] last = {1'b0, memAddr} + 65'd15;
    if (early) begin tag = "R3"; return 6'b000010; end
    if (cr0Ts) begin tag = "R4"; return 6'b000100; end
    if (memOp) begin
      if (cpuMode == 3'd0 || cpuMode == 3'd1) begin
        if (last > 65'hFFFF) begin tag = "R7"; return 6'b001000; end
      end else if (cpuMode == 3'd4) begin
        if (!addrCanonical) begin
          tag = "R6"; return stackRef ? 6'b010000 : 6'b001000;
        end
      end else if (segFault) begin
        tag = (cpuMode > 3'd4) ? "R5" : "R8";
        return stackRef ? 6'b010000 : 6'b001000;
      end
      if (memAddr[3:0] != 4'd0) begin tag = "R9"; return 6'b001000; end
    end
    if (numFault) begin tag = "R11"; return cr4XmmExc ? 6'b100000 : 6'b000010; end
    tag = memOp ? "R11" : "R10";
    return 6'b000001;
  endfunction

  task automatic checkNow(input string tag, input logic [5:0] expCode);
    checks++;
    if (faultValid !== 1'b1 || faultCode !== expCode) begin
      errors++;
      $display("FAIL %s mode=%0d valid=%b code=%b expected valid=1 code=%b",
               tag, cpuMode, faultValid, faultCode, expCode);
    end
  endtask

  // inputs already set; drive valid, wait through the register, compare
  task automatic applyOne(input string over);
    string tag;
    logic [5:0] exp;
    reqValid = 1'b1;
    exp = refCode(tag);
    if (over != "") tag = over;
    @(negedge clk);
    checkNow(tag, exp);
  endtask

  task automatic setCtl(input logic [6:0] b);
    {cr0Em, cr0Ts, cr4Fxsr, cr4XmmExc, featPresent, lockPrefix, numFault} = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (faultValid !== 1'b0 || faultCode !== 6'b000001) begin
      errors++;
      $display("FAIL R1 reset valid=%b code=%b expected valid=0 code=000001", faultValid, faultCode);
    end
    rstN = 1'b1;
    @(negedge clk);
    // R2 idle keeps valid low
    checks++;
    if (faultValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle valid=%b expected 0", faultValid);
    end

    // exhaustive sweep: mode x control bits x address patterns
    for (int m = 0; m < 5; m++) begin
      for (int c = 0; c < 128; c++) begin
        for (int a = 0; a < 4; a++) begin
          cpuMode = 3'(m);
          setCtl(7'(c));
          addrCanonical = 1; stackRef = 0; segFault = 0;
          case (a)
            0: begin memOp = 0; memAddr = 64'hFFFF_FFFF_FFFF_FFF3; addrCanonical = 0; segFault = 1; end
            1: begin memOp = 1; memAddr = 64'h0000_0000_0000_1230; end
            2: begin memOp = 1; memAddr = 64'h0000_0000_0000_1238; end
            default: begin memOp = 1; memAddr = 64'h0000_0000_0002_0000; end
          endcase
          applyOne("");
        end
      end
    end

    // directed corners
    setCtl(7'b0010100); // fxsr=1 feat=1, no other
    cpuMode = 3'd0; memOp = 1; addrCanonical = 1; stackRef = 0; segFault = 0;
    memAddr = 64'h0000_FFF0; applyOne("R7");  // last legal slot
    memAddr = 64'h0000_FFF1; applyOne("R7");
    memAddr = 64'h0001_0000; applyOne("R7");
    cpuMode = 3'd1; memAddr = 64'h0000_FFF0; applyOne("R7");
    cpuMode = 3'd4; memAddr = 64'h8000_0000_0000_0004; addrCanonical = 0; stackRef = 1;
    applyOne("R6");                            // SS beats alignment GP
    stackRef = 0; applyOne("R6");
    cpuMode = 3'd6; addrCanonical = 1; segFault = 1; stackRef = 1; memAddr = 64'h40;
    applyOne("R5");
    cpuMode = 3'd3; stackRef = 0; applyOne("R8");
    cpuMode = 3'd2; segFault = 0; memAddr = 64'h41; applyOne("R9");
    memOp = 0; segFault = 1; addrCanonical = 0; memAddr = 64'h3; numFault = 1; cr4XmmExc = 1;
    applyOne("R10");
    cr4XmmExc = 0; applyOne("R11");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cpuMode       = 3'($urandom_range(0, 7));
      setCtl(7'($urandom));
      if ($urandom_range(0, 3) != 0) begin cr0Em = 0; cr4Fxsr = 1; featPresent = 1; lockPrefix = 0; end
      if ($urandom_range(0, 2) != 0) cr0Ts = 0;
      memOp         = 1'($urandom);
      addrCanonical = ($urandom_range(0, 3) != 0);
      stackRef      = 1'($urandom);
      segFault      = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 2))
        0: memAddr = {$urandom, $urandom};
        1: memAddr = 64'($urandom_range(32'hFFE0, 32'h1_0010));
        default: memAddr = 64'($urandom) & ~64'hF;
      endcase
      applyOne("");
    end

    // R2 valid drop
    reqValid = 1'b0;
    @(negedge clk);
    checks++;
    if (faultValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 valid=%b expected 0 after request drop", faultValid);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule